// File: doc/BRIEF.md
# Timeslot-16 Signalling Multiplexer

This block assembles the byte carried in timeslot 16 of every frame of a 16-frame signalling multiframe on a 32-slot E1-style line. Its input is a parallel form of a control stream: each valid cycle delivers one byte together with the number of the control slot it belongs to. Control slot 0 holds the spare bits of the multiframe alignment word. Slots 1 to 15 each hold the ABCD signalling bits of two voice channels. Slots 16, 17 and 18 hold the frame alignment byte, the non-frame alignment byte and the third master control word. These three bytes are also presented on output ports of their own.

A frame pulse advances a multiframe counter, which selects the timeslot-16 byte. In frame 0 the byte is four zeros followed by the four spare bits from control slot 0. In frame k (1 to 15) the byte is the content of control slot k. The upper nibble carries the ABCD bits of channel k and the lower nibble carries those of channel k+16. All control bytes first go into a shadow store. They are copied to the active store only at the multiframe boundary, so one multiframe never mixes data from two control frames.

Top module: `ts16_sig_mux`

## Requirements
- R1: After reset, `mf_index` is 0 and `ts16_byte`, `fas_byte`, `nfas_byte` and `mcw3_byte` are all 0x00.
- R2: Each cycle with `frm_pulse` high advances `mf_index` by one on the next edge, and 15 wraps to 0. Without a pulse, `mf_index` holds.
- R3: While `mf_index` is 0, `ts16_byte` is {4'b0000, bits [3:0] of the active slot-0 byte}. Bits [7:4] of slot 0 never reach the line.
- R4: While `mf_index` is k (1 to 15), `ts16_byte` equals the active byte of control slot k. Bits [7:4] hold the ABCD bits of channel k, with A in bit 7. Bits [3:0] hold the ABCD bits of channel k+16, with A in bit 3.
- R5: `fas_byte`, `nfas_byte` and `mcw3_byte` equal the active bytes of control slots 16, 17 and 18.
- R6: A control byte written during a multiframe has no effect on any output until the frame pulse that moves `mf_index` from 15 to 0. Between boundaries, `fas_byte`, `nfas_byte` and `mcw3_byte` stay constant, and `ts16_byte` changes only after a frame pulse.
- R7: A byte written in the same cycle as the wrapping frame pulse is not part of that transfer. It appears at the following boundary.
- R8: Writes to control slots 19 to 31 are ignored and change no output.
- R9: When one slot is written several times within a multiframe, the last value written before the boundary is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_pulse | input | 1 | One-cycle strobe at the start of each line frame |
| ctl_valid | input | 1 | Qualifies `ctl_slot` and `ctl_byte` |
| ctl_slot | input | 5 | Control slot number of the presented byte |
| ctl_byte | input | 8 | Control byte |
| mf_index | output | 4 | Current frame number within the multiframe |
| ts16_byte | output | 8 | Timeslot-16 content for the current frame |
| fas_byte | output | 8 | Active frame alignment byte |
| nfas_byte | output | 8 | Active non-frame alignment byte |
| mcw3_byte | output | 8 | Active master control word 3 |

## Verification
The bench uses the default parameters: 32 control slots and a 16-frame multiframe. With these values, a random 5-bit slot number reaches both the 19 held slots and the 13 ignored ones, and a frame pulse rate of about one in three crosses the multiframe boundary many dozens of times. Directed sequences place a write on the wrapping pulse itself, write one slot twice within a multiframe, and sweep through all sixteen frames, so that each frame's timeslot-16 byte is compared against the bench model.

// File: rtl/ts16_mux_pkg.sv
package ts16_mux_pkg;

  typedef logic [7:0] octet_t;

  typedef enum logic [2:0] {
    ROLE_MFAS,
    ROLE_SIG,
    ROLE_FAS,
    ROLE_NFAS,
    ROLE_MCW,
    ROLE_SPARE
  } slot_role_e;

  // Role of a control slot for a multiframe of 'frames' frames.
  function automatic slot_role_e role_of(input int unsigned idx,
                                         input int unsigned frames);
    slot_role_e r;
    if (idx == 0)                 r = ROLE_MFAS;
    else if (idx < frames)        r = ROLE_SIG;
    else if (idx == frames)       r = ROLE_FAS;
    else if (idx == frames + 1)   r = ROLE_NFAS;
    else if (idx == frames + 2)   r = ROLE_MCW;
    else                          r = ROLE_SPARE;
    return r;
  endfunction

endpackage

// File: rtl/ts16_rst_sync.sv
module ts16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/ts16_mf_counter.sv
module ts16_mf_counter #(
  parameter int unsigned MF_FRAMES = 16,
  localparam int unsigned CNT_W = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_pulse,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_FRAMES - 1);

  logic [CNT_W-1:0] cnt_d;

  assign wrap = frm_pulse && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (frm_pulse) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ts16_ctl_bank.sv
module ts16_ctl_bank
  import ts16_mux_pkg::*;
#(
  parameter int unsigned HELD   = 19,
  parameter int unsigned SLOT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  octet_t               wr_byte,
  input  logic                 xfer,
  output octet_t [HELD-1:0]    act_q
);
  for (genvar i = 0; i < HELD; i++) begin : g_ent
    octet_t sh_q, sh_d;
    octet_t ac_q, ac_d;
    logic   sel;

    assign sel = wr_en && (wr_slot == SLOT_W'(i));

    always_comb begin
      sh_d = sh_q;
      if (sel) sh_d = wr_byte;
    end

    always_comb begin
      ac_d = ac_q;
      if (xfer) ac_d = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        ac_q <= '0;
      end else begin
        sh_q <= sh_d;
        ac_q <= ac_d;
      end
    end

    assign act_q[i] = ac_q;
  end
endmodule

// File: rtl/ts16_slot_sel.sv
module ts16_slot_sel
  import ts16_mux_pkg::*;
#(
  parameter int unsigned HELD  = 19,
  parameter int unsigned CNT_W = 4
) (
  input  octet_t [HELD-1:0] act,
  input  logic [CNT_W-1:0]  frame,
  output octet_t            ts16
);
  localparam int unsigned IDX_W = $clog2(HELD);

  always_comb begin
    if (frame == '0) ts16 = {4'b0000, act[0][3:0]};
    else             ts16 = act[IDX_W'(frame)];
  end
endmodule

// File: rtl/ts16_sig_mux.sv
module ts16_sig_mux
  import ts16_mux_pkg::*;
#(
  parameter int unsigned CTL_SLOTS = 32,
  parameter int unsigned MF_FRAMES = 16,
  localparam int unsigned SLOT_W = $clog2(CTL_SLOTS),
  localparam int unsigned CNT_W  = $clog2(MF_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_pulse,
  input  logic              ctl_valid,
  input  logic [SLOT_W-1:0] ctl_slot,
  input  logic [7:0]        ctl_byte,
  output logic [CNT_W-1:0]  mf_index,
  output logic [7:0]        ts16_byte,
  output logic [7:0]        fas_byte,
  output logic [7:0]        nfas_byte,
  output logic [7:0]        mcw3_byte
);
  localparam int unsigned HELD     = MF_FRAMES + 3;
  localparam int unsigned FAS_IDX  = MF_FRAMES;
  localparam int unsigned NFAS_IDX = MF_FRAMES + 1;
  localparam int unsigned MCW_IDX  = MF_FRAMES + 2;

  logic              rst_sync_n;
  logic              mf_wrap;
  logic              wr_ok;
  octet_t [HELD-1:0] act;

  ts16_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  ts16_mf_counter #(.MF_FRAMES(MF_FRAMES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frm_pulse (frm_pulse),
    .cnt_q     (mf_index),
    .wrap      (mf_wrap)
  );

  always_comb begin
    wr_ok = ctl_valid && (role_of(int'(ctl_slot), MF_FRAMES) != ROLE_SPARE);
  end

  ts16_ctl_bank #(.HELD(HELD), .SLOT_W(SLOT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_ok),
    .wr_slot (ctl_slot),
    .wr_byte (ctl_byte),
    .xfer    (mf_wrap),
    .act_q   (act)
  );

  ts16_slot_sel #(.HELD(HELD), .CNT_W(CNT_W)) u_sel (
    .act   (act),
    .frame (mf_index),
    .ts16  (ts16_byte)
  );

  assign fas_byte  = act[FAS_IDX];
  assign nfas_byte = act[NFAS_IDX];
  assign mcw3_byte = act[MCW_IDX];
endmodule

// File: rtl/ts16_sig_mux_chk.sv
module ts16_sig_mux_chk #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned MF_FRAMES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_pulse,
  input logic [CNT_W-1:0] mf_index,
  input logic [7:0]       ts16_byte,
  input logic [7:0]       fas_byte,
  input logic [7:0]       nfas_byte,
  input logic [7:0]       mcw3_byte
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_FRAMES - 1);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_pulse && mf_index != LAST) |=> (mf_index == $past(mf_index) + 1'b1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_pulse && mf_index == LAST) |=> (mf_index == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_pulse |=> $stable(mf_index));

  a_r3_frame0_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_index == '0) |-> (ts16_byte[7:4] == 4'b0000));

  a_r6_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_pulse && mf_index == LAST) |=>
      ($stable(fas_byte) && $stable(nfas_byte) && $stable(mcw3_byte)));

  a_r6_ts16_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_pulse |=> $stable(ts16_byte));
endmodule

bind ts16_sig_mux ts16_sig_mux_chk #(.CNT_W(CNT_W), .MF_FRAMES(MF_FRAMES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frm_pulse (frm_pulse),
  .mf_index  (mf_index),
  .ts16_byte (ts16_byte),
  .fas_byte  (fas_byte),
  .nfas_byte (nfas_byte),
  .mcw3_byte (mcw3_byte)
);

// File: tb/tb_ts16_sig_mux.sv
`timescale 1ns/1ps
module tb_ts16_sig_mux;
  localparam int NHELD = 19;

  logic       clk;
  logic       rst_n;
  logic       frm_pulse;
  logic       ctl_valid;
  logic [4:0] ctl_slot;
  logic [7:0] ctl_byte;
  logic [3:0] mf_index;
  logic [7:0] ts16_byte, fas_byte, nfas_byte, mcw3_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_sh  [NHELD];
  logic [7:0] m_act [NHELD];
  int         m_cnt;

  ts16_sig_mux dut (
    .clk(clk), .rst_n(rst_n), .frm_pulse(frm_pulse), .ctl_valid(ctl_valid),
    .ctl_slot(ctl_slot), .ctl_byte(ctl_byte), .mf_index(mf_index),
    .ts16_byte(ts16_byte), .fas_byte(fas_byte), .nfas_byte(nfas_byte),
    .mcw3_byte(mcw3_byte)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_ts16(input int frame);
    if (frame == 0) return {4'b0000, m_act[0][3:0]};
    return m_act[frame];
  endfunction

  task automatic check_all();
    chk("R2 mf_index", int'(mf_index), m_cnt);
    if (m_cnt == 0) chk("R3 ts16 frame0", int'(ts16_byte), int'(exp_ts16(0)));
    else            chk("R4 ts16 signalling", int'(ts16_byte), int'(exp_ts16(m_cnt)));
    chk("R5 fas_byte",  int'(fas_byte),  int'(m_act[16]));
    chk("R5 nfas_byte", int'(nfas_byte), int'(m_act[17]));
    chk("R5 mcw3_byte", int'(mcw3_byte), int'(m_act[18]));
  endtask

  // One cycle of stimulus followed by the model update and a full compare.
  task automatic step(input bit fp, input bit wv, input int sl, input int by);
    @(negedge clk);
    frm_pulse = fp; ctl_valid = wv; ctl_slot = 5'(sl); ctl_byte = 8'(by);
    @(posedge clk);
    if (fp) begin
      if (m_cnt == 15) foreach (m_act[i]) m_act[i] = m_sh[i];
      m_cnt = (m_cnt + 1) % 16;
    end
    if (wv && sl < NHELD) m_sh[sl] = 8'(by);
    #1;
    check_all();
  endtask

  task automatic goto_frame(input int target);
    while (m_cnt != target) step(1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'h5EED_0716));
    frm_pulse = 0; ctl_valid = 0; ctl_slot = 0; ctl_byte = 0;
    foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
    m_cnt = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 mf_index",  int'(mf_index),  0);
    chk("R1 ts16_byte", int'(ts16_byte), 0);
    chk("R1 fas_byte",  int'(fas_byte),  0);
    chk("R1 nfas_byte", int'(nfas_byte), 0);
    chk("R1 mcw3_byte", int'(mcw3_byte), 0);

    // R3/R4: load every slot with a distinct pattern, then sweep all frames
    for (int s = 0; s < NHELD; s++) step(1'b0, 1'b1, s, 8'h30 + s * 7);
    step(1'b0, 1'b1, 0, 8'hF9);  // upper nibble of slot 0 must be dropped
    goto_frame(15);
    step(1'b1, 1'b0, 0, 0);
    chk("R3 frame0 upper zero", int'(ts16_byte), 32'h09);
    for (int f = 1; f < 16; f++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R4 frame sweep", int'(ts16_byte), (8'h30 + f * 7) & 8'hFF);
    end

    // R6: mid-multiframe write invisible until boundary
    goto_frame(4);
    keep = fas_byte;
    step(1'b0, 1'b1, 16, 8'hC3);
    step(1'b1, 1'b0, 0, 0);
    chk("R6 fas held mid-multiframe", int'(fas_byte), int'(keep));
    goto_frame(0);
    chk("R6 fas after boundary", int'(fas_byte), 32'hC3);

    // R7: write on the wrapping pulse waits one more multiframe
    goto_frame(15);
    step(1'b1, 1'b1, 18, 8'h5A);
    chk("R7 same-cycle write not taken", int'(mcw3_byte), int'(m_act[18]));
    chk("R7 mcw3 still old", int'(mcw3_byte == 8'h5A), 0);
    goto_frame(15);
    step(1'b1, 1'b0, 0, 0);
    chk("R7 taken next boundary", int'(mcw3_byte), 32'h5A);

    // R9: last write wins
    step(1'b1, 1'b1, 17, 8'h11);
    step(1'b0, 1'b1, 17, 8'h22);
    step(1'b0, 1'b1, 17, 8'h77);
    goto_frame(0);
    chk("R9 last write wins", int'(nfas_byte), 32'h77);

    // R8: spare slots ignored
    for (int s = NHELD; s < 32; s++) step(1'b0, 1'b1, s, 8'hEE);
    goto_frame(15);
    step(1'b1, 1'b0, 0, 0);
    chk("R8 spare writes ignored fas", int'(fas_byte), 32'hC3);
    chk("R8 spare writes ignored mcw3", int'(mcw3_byte), 32'h5A);
    for (int f = 1; f < 16; f++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R8 spare writes ignored ts16", int'(ts16_byte), int'(exp_ts16(f)));
    end

    // Constrained random traffic checked every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 3) == 0, ($urandom % 2) == 0, $urandom % 32, $urandom % 256);
    end
    step(1'b0, 1'b0, 0, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule